// File: doc/BRIEF.md
# Cache-Line Invalidation Broadcast and Sync Hub

This hub keeps DMA writes coherent with the write-through L1 data caches of several CPUs. The caches write through and drop lines on invalidation, so no dirty data is ever written back. The hub only has to tell every cache which line went stale.

Each accepted DMA write beat becomes one entry in an in-order tracking queue. The entry holds the 64-byte line address and the identity of the master that wrote it. Every CPU has its own invalidation request stream, and each stream walks the queue at its own pace under valid/ready. Each CPU returns acknowledgements in issue order on its own ack stream. Once every CPU has acknowledged the oldest entry, the hub offers a sync beat tagged with the originating master. The entry retires when that beat is accepted.

The hub also sits in the return path of MMIO read responses. When a response arrives, the hub counts the invalidations that have not yet retired at that moment. It holds the response until exactly that many have retired. Invalidations accepted after the response arrived do not lengthen the hold. A per-master pending flag lets software poll for completion instead of relying on the held response.

Top module: `inv_sync_hub`

## Requirements
- R1: Every accepted snoop beat (`snoopValid && snoopReady` at a rising edge) produces exactly one request on each CPU's `invValid` stream. Requests appear in acceptance order, and each carries the line address `snoopAddr[ADDR_W-1:6]` on that CPU's slice of `invLine` (CPU c uses bits `[c*LINE_W +: LINE_W]`).
- R2: The CPU request streams are independent. A CPU holding `invReady` low never stops another CPU from receiving its requests. While valid is high and ready is low, a CPU's valid and line address stay unchanged.
- R3: `syncValid` rises for the oldest outstanding entry only after every CPU has acknowledged it. `syncMaster` carries that entry's master, and syncs come out in acceptance order. While `syncReady` is low, the sync beat stays unchanged.
- R4: At most DEPTH (default 8) invalidations are outstanding. `snoopReady` is low exactly when DEPTH entries are outstanding.
- R5: `ackReady` for a CPU is high only while that CPU has been sent requests it has not yet acknowledged. Acks are taken in issue order.
- R6: An MMIO response accepted while N invalidations are outstanding makes `rspOutValid` rise in the cycle after the N-th of them retires. With N = 0, it rises in the cycle after acceptance.
- R7: Invalidations accepted after an MMIO response was taken never delay that response.
- R8: `statusPending[m]` is high exactly while master m has accepted snoop beats whose sync has not yet been accepted.
- R9: After reset, `snoopReady` and `rspInReady` are high. `invValid`, `ackReady`, `syncValid`, `rspOutValid` and `statusPending` are all zero.
- R10: The hub holds one MMIO response at a time. `rspInReady` stays low while a response is held. The held data goes out unchanged on `rspOutData` and stays stable until `rspOutReady` takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| snoopValid | input | 1 | Snooped DMA write beat valid |
| snoopReady | output | 1 | Hub can accept a snooped beat |
| snoopAddr | input | ADDR_W | Byte address of the DMA write |
| snoopMaster | input | MID_W | Master that issued the write |
| invValid | output | NUM_CPU | Per-CPU invalidation request valid |
| invReady | input | NUM_CPU | Per-CPU invalidation request ready |
| invLine | output | NUM_CPU*LINE_W | Per-CPU line address of the request |
| ackValid | input | NUM_CPU | Per-CPU invalidation-done valid |
| ackReady | output | NUM_CPU | Per-CPU ack accepted |
| syncValid | output | 1 | Completion beat for the oldest entry |
| syncReady | input | 1 | Master accepts the completion beat |
| syncMaster | output | MID_W | Master owning the completed entry |
| rspInValid | input | 1 | MMIO read response arriving |
| rspInReady | output | 1 | Response buffer empty |
| rspInData | input | DATA_W | MMIO read response data |
| rspOutValid | output | 1 | Released MMIO response valid |
| rspOutReady | input | 1 | Requester accepts the response |
| rspOutData | output | DATA_W | Released MMIO response data |
| statusPending | output | NUM_MST | Per-master invalidations still pending |

## Verification
The embedded assertions check, on every cycle, the invariants that tie separate pieces of state together. These are: the occupancy never exceeds DEPTH; the per-master pending counters sum to the occupancy; no CPU's ack pointer runs ahead of its send pointer; a held response never waits on more retirements than are outstanding; and the inv, sync and response beats stay stable under backpressure. Only the bench's scenarios can show the values themselves. That covers the line addresses on each CPU stream, the order of sync masters, and the exact cycle at which a held response is released for every number of earlier invalidations from zero to full. It also covers the fact that later invalidations leave that cycle unchanged.

// File: rtl/invhub_pkg.sv
package invhub_pkg;

  // Byte offset bits inside one cache line (64-byte lines).
  localparam int LINE_BITS = 6;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic push;     // store a new tracking entry
    logic rspLoad;  // capture an incoming MMIO response
  } hubStrobe_t;

endpackage

// File: rtl/invhub_dp.sv
module invhub_dp
  import invhub_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int MID_W   = 1,
  parameter int DEPTH   = 8,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int LINE_W = ADDR_W - LINE_BITS
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  hubStrobe_t                strobe,
  input  logic [PTR_W-1:0]          wrIdx,
  input  logic [PTR_W-1:0]          rdIdx,
  input  logic [NUM_CPU*PTR_W-1:0]  sendIdx,
  input  logic [ADDR_W-1:0]         snoopAddr,
  input  logic [MID_W-1:0]          snoopMaster,
  input  logic [DATA_W-1:0]         rspInData,
  output logic [NUM_CPU*LINE_W-1:0] invLine,
  output logic [MID_W-1:0]          headMaster,
  output logic [DATA_W-1:0]         rspOutData
);

  logic [LINE_W-1:0] lineMem [DEPTH];
  logic [MID_W-1:0]  mstMem  [DEPTH];
  logic [DATA_W-1:0] rspReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        lineMem[i] <= '0;
        mstMem[i]  <= '0;
      end
    end else if (strobe.push) begin
      lineMem[wrIdx] <= snoopAddr[ADDR_W-1:LINE_BITS];
      mstMem[wrIdx]  <= snoopMaster;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               rspReg <= '0;
    else if (strobe.rspLoad) rspReg <= rspInData;
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpuLine
    assign invLine[c*LINE_W +: LINE_W] = lineMem[sendIdx[c*PTR_W +: PTR_W]];
  end

  assign headMaster = mstMem[rdIdx];
  assign rspOutData = rspReg;

endmodule

// File: rtl/invhub_ctrl.sv
module invhub_ctrl
  import invhub_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int NUM_MST = 2,
  parameter int MID_W   = 1,
  parameter int DEPTH   = 8,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int SEQ_W  = PTR_W + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     snoopValid,
  output logic                     snoopReady,
  input  logic [MID_W-1:0]         snoopMaster,
  output logic [NUM_CPU-1:0]       invValid,
  input  logic [NUM_CPU-1:0]       invReady,
  input  logic [NUM_CPU-1:0]       ackValid,
  output logic [NUM_CPU-1:0]       ackReady,
  output logic                     syncValid,
  input  logic                     syncReady,
  input  logic [MID_W-1:0]         headMaster,
  input  logic                     rspInValid,
  output logic                     rspInReady,
  output logic                     rspOutValid,
  input  logic                     rspOutReady,
  output logic [NUM_MST-1:0]       statusPending,
  output hubStrobe_t               strobe,
  output logic [PTR_W-1:0]         wrIdx,
  output logic [PTR_W-1:0]         rdIdx,
  output logic [NUM_CPU*PTR_W-1:0] sendIdx
);

  logic [SEQ_W-1:0] wrPtr, rdPtr, count;
  logic [SEQ_W-1:0] sendPtr [NUM_CPU];
  logic [SEQ_W-1:0] ackPtr  [NUM_CPU];
  logic [SEQ_W-1:0] pendCnt [NUM_MST];
  logic             allAcked, retire, push;
  logic             held;
  logic [SEQ_W-1:0] remain;
  logic             rspLoad, rspDrop;

  assign count      = wrPtr - rdPtr;
  assign snoopReady = (count != SEQ_W'(DEPTH));
  assign push       = snoopValid && snoopReady;

  always_comb begin
    allAcked = (count != '0);
    for (int c = 0; c < NUM_CPU; c++) allAcked = allAcked && (ackPtr[c] != rdPtr);
  end

  assign syncValid = allAcked;
  assign retire    = syncValid && syncReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (push)   wrPtr <= wrPtr + 1'b1;
      if (retire) rdPtr <= rdPtr + 1'b1;
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    assign invValid[c] = (sendPtr[c] != wrPtr);
    assign ackReady[c] = (ackPtr[c] != sendPtr[c]);
    assign sendIdx[c*PTR_W +: PTR_W] = sendPtr[c][PTR_W-1:0];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        sendPtr[c] <= '0;
        ackPtr[c]  <= '0;
      end else begin
        if (invValid[c] && invReady[c]) sendPtr[c] <= sendPtr[c] + 1'b1;
        if (ackValid[c] && ackReady[c]) ackPtr[c]  <= ackPtr[c] + 1'b1;
      end
    end

    // R5
    ack_behind_send_chk: assert property (@(posedge clk) disable iff (!rstN)
      (SEQ_W'(ackPtr[c] - rdPtr) <= SEQ_W'(sendPtr[c] - rdPtr)) &&
      (SEQ_W'(sendPtr[c] - rdPtr) <= count));
  end

  for (genvar m = 0; m < NUM_MST; m++) begin : g_mst
    logic incM, decM;
    assign incM = push && (snoopMaster == MID_W'(m));
    assign decM = retire && (headMaster == MID_W'(m));
    assign statusPending[m] = (pendCnt[m] != '0);

    always_ff @(posedge clk) begin
      if (!rstN) pendCnt[m] <= '0;
      else if (incM && !decM) pendCnt[m] <= pendCnt[m] + 1'b1;
      else if (decM && !incM) pendCnt[m] <= pendCnt[m] - 1'b1;
    end
  end

  // MMIO response hold: remember how many entries were ahead of it.
  assign rspInReady  = !held;
  assign rspLoad     = rspInValid && !held;
  assign rspOutValid = held && (remain == '0);
  assign rspDrop     = rspOutValid && rspOutReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      held   <= 1'b0;
      remain <= '0;
    end else if (rspLoad) begin
      held   <= 1'b1;
      remain <= count - SEQ_W'(retire);
    end else begin
      if (retire && remain != '0) remain <= remain - 1'b1;
      if (rspDrop) held <= 1'b0;
    end
  end

  assign strobe.push    = push;
  assign strobe.rspLoad = rspLoad;
  assign wrIdx = wrPtr[PTR_W-1:0];
  assign rdIdx = rdPtr[PTR_W-1:0];

  int pendSum;
  always_comb begin
    pendSum = 0;
    for (int m = 0; m < NUM_MST; m++) pendSum += int'(pendCnt[m]);
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= SEQ_W'(DEPTH));

  // R8
  pend_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendSum == int'(count));

  // R6
  remain_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    held |-> (remain <= count));

endmodule

// File: rtl/inv_sync_hub.sv
module inv_sync_hub
  import invhub_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int NUM_MST = 2,
  parameter int DEPTH   = 8,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  localparam int MID_W  = (NUM_MST > 1) ? $clog2(NUM_MST) : 1,
  localparam int LINE_W = ADDR_W - LINE_BITS
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      snoopValid,
  output logic                      snoopReady,
  input  logic [ADDR_W-1:0]         snoopAddr,
  input  logic [MID_W-1:0]          snoopMaster,
  output logic [NUM_CPU-1:0]        invValid,
  input  logic [NUM_CPU-1:0]        invReady,
  output logic [NUM_CPU*LINE_W-1:0] invLine,
  input  logic [NUM_CPU-1:0]        ackValid,
  output logic [NUM_CPU-1:0]        ackReady,
  output logic                      syncValid,
  input  logic                      syncReady,
  output logic [MID_W-1:0]          syncMaster,
  input  logic                      rspInValid,
  output logic                      rspInReady,
  input  logic [DATA_W-1:0]         rspInData,
  output logic                      rspOutValid,
  input  logic                      rspOutReady,
  output logic [DATA_W-1:0]         rspOutData,
  output logic [NUM_MST-1:0]        statusPending
);

  localparam int PTR_W = $clog2(DEPTH);

  hubStrobe_t               strobe;
  logic [PTR_W-1:0]         wrIdx, rdIdx;
  logic [NUM_CPU*PTR_W-1:0] sendIdx;
  logic [MID_W-1:0]         headMaster;

  invhub_ctrl #(
    .NUM_CPU(NUM_CPU), .NUM_MST(NUM_MST), .MID_W(MID_W), .DEPTH(DEPTH)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .snoopValid(snoopValid), .snoopReady(snoopReady), .snoopMaster(snoopMaster),
    .invValid(invValid), .invReady(invReady),
    .ackValid(ackValid), .ackReady(ackReady),
    .syncValid(syncValid), .syncReady(syncReady), .headMaster(headMaster),
    .rspInValid(rspInValid), .rspInReady(rspInReady),
    .rspOutValid(rspOutValid), .rspOutReady(rspOutReady),
    .statusPending(statusPending),
    .strobe(strobe), .wrIdx(wrIdx), .rdIdx(rdIdx), .sendIdx(sendIdx)
  );

  invhub_dp #(
    .NUM_CPU(NUM_CPU), .MID_W(MID_W), .DEPTH(DEPTH),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrIdx(wrIdx), .rdIdx(rdIdx), .sendIdx(sendIdx),
    .snoopAddr(snoopAddr), .snoopMaster(snoopMaster), .rspInData(rspInData),
    .invLine(invLine), .headMaster(headMaster), .rspOutData(rspOutData)
  );

  assign syncMaster = headMaster;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_invChk
    // R2
    inv_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (invValid[c] && !invReady[c]) |=>
        (invValid[c] && $stable(invLine[c*LINE_W +: LINE_W])));
  end

  // R3
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (syncValid && !syncReady) |=> (syncValid && $stable(syncMaster)));

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspOutValid && !rspOutReady) |=> (rspOutValid && $stable(rspOutData) && !rspInReady));

endmodule

// File: tb/tb_inv_sync_hub.sv
module tb_inv_sync_hub;

  localparam int NCPU = 2;
  localparam int NMST = 2;
  localparam int DEP  = 8;
  localparam int AW   = 32;
  localparam int DW   = 32;
  localparam int LW   = AW - 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic snoopValid = 1'b0;
  logic snoopReady;
  logic [AW-1:0] snoopAddr = '0;
  logic [0:0] snoopMaster = '0;
  logic [NCPU-1:0] invValid;
  logic [NCPU-1:0] invReady = '0;
  logic [NCPU*LW-1:0] invLine;
  logic [NCPU-1:0] ackValid = '0;
  logic [NCPU-1:0] ackReady;
  logic syncValid;
  logic syncReady = 1'b0;
  logic [0:0] syncMaster;
  logic rspInValid = 1'b0;
  logic rspInReady;
  logic [DW-1:0] rspInData = '0;
  logic rspOutValid;
  logic rspOutReady = 1'b0;
  logic [DW-1:0] rspOutData;
  logic [NMST-1:0] statusPending;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  inv_sync_hub #(.NUM_CPU(NCPU), .NUM_MST(NMST), .DEPTH(DEP), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN),
    .snoopValid(snoopValid), .snoopReady(snoopReady),
    .snoopAddr(snoopAddr), .snoopMaster(snoopMaster),
    .invValid(invValid), .invReady(invReady), .invLine(invLine),
    .ackValid(ackValid), .ackReady(ackReady),
    .syncValid(syncValid), .syncReady(syncReady), .syncMaster(syncMaster),
    .rspInValid(rspInValid), .rspInReady(rspInReady), .rspInData(rspInData),
    .rspOutValid(rspOutValid), .rspOutReady(rspOutReady), .rspOutData(rspOutData),
    .statusPending(statusPending)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pushOne(logic [AW-1:0] addr, logic mst);
    snoopValid  = 1'b1;
    snoopAddr   = addr;
    snoopMaster = mst;
    for (int w = 0; w < 200 && !snoopReady; w++) tick();
    tick();
    snoopValid = 1'b0;
  endtask

  function automatic logic [LW-1:0] lineOf(int c);
    return invLine[c*LW +: LW];
  endfunction

  initial begin
    #(20 * 150000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int accepted;
    int seen;
    @(negedge clk);
    repeat (3) tick();
    rstN = 1'b1;

    // R9 reset state
    check("R9 snoopReady", 64'(snoopReady), 64'd1);
    check("R9 rspInReady", 64'(rspInReady), 64'd1);
    check("R9 invValid", 64'(invValid), 64'd0);
    check("R9 ackReady", 64'(ackReady), 64'd0);
    check("R9 syncValid", 64'(syncValid), 64'd0);
    check("R9 rspOutValid", 64'(rspOutValid), 64'd0);
    check("R9 statusPending", 64'(statusPending), 64'd0);

    // R4: fill with stalled CPUs, alternating masters
    accepted = 0;
    for (int i = 0; i < DEP + 2; i++) begin
      snoopValid  = 1'b1;
      snoopAddr   = 32'h1000 + 32'(i * 64) + 32'((i * 7) % 64);
      snoopMaster = 1'(i % 2);
      if (snoopReady) accepted++;
      tick();
    end
    snoopValid = 1'b0;
    check("R4 accepted count", 64'(accepted), 64'(DEP));
    check("R4 snoopReady full", 64'(snoopReady), 64'd0);
    check("R8 both pending", 64'(statusPending), 64'b11);
    check("R1 both valid", 64'(invValid), 64'b11);
    check("R1 cpu1 head line", 64'(lineOf(1)), 64'd64);

    // R1 / R2: drain CPU0 only, CPU1 stalled
    invReady = 2'b01;
    for (int k = 0; k < DEP; k++) begin
      check("R1 cpu0 valid", 64'(invValid[0]), 64'd1);
      check("R1 cpu0 line", 64'(lineOf(0)), 64'(64 + k));
      check("R2 cpu1 held line", 64'(lineOf(1)), 64'd64);
      tick();
    end
    invReady = 2'b00;
    check("R2 cpu0 empty cpu1 waiting", 64'(invValid), 64'b10);
    check("R3 no sync before acks", 64'(syncValid), 64'd0);

    // R5: acks from CPU0
    ackValid = 2'b01;
    for (int k = 0; k < DEP; k++) begin
      check("R5 cpu0 ackReady", 64'(ackReady[0]), 64'd1);
      tick();
    end
    ackValid = 2'b00;
    check("R5 cpu0 all acked", 64'(ackReady[0]), 64'd0);
    check("R5 cpu1 nothing sent", 64'(ackReady[1]), 64'd0);
    check("R3 cpu1 missing", 64'(syncValid), 64'd0);

    // CPU1 one request and ack at a time
    for (int k = 0; k < DEP; k++) begin
      invReady = 2'b10;
      tick();
      invReady = 2'b00;
      check("R5 cpu1 ackReady", 64'(ackReady[1]), 64'd1);
      ackValid = 2'b10;
      tick();
      ackValid = 2'b00;
      check("R3 sync after all acks", 64'(syncValid), 64'd1);
      check("R3 head master", 64'(syncMaster), 64'd0);
    end

    // R3 / R8: consume syncs in order
    syncReady = 1'b1;
    for (int k = 0; k < DEP; k++) begin
      check("R3 sync valid", 64'(syncValid), 64'd1);
      check("R3 sync master order", 64'(syncMaster), 64'(k % 2));
      check("R8 pending", 64'(statusPending), (k < DEP - 1) ? 64'b11 : 64'b10);
      tick();
    end
    syncReady = 1'b0;
    check("R3 drained", 64'(syncValid), 64'd0);
    check("R8 none pending", 64'(statusPending), 64'd0);
    check("R4 ready again", 64'(snoopReady), 64'd1);

    // R6 / R7 / R10: sweep over number of earlier invalidations
    for (int n = 0; n <= DEP; n++) begin
      for (int i = 0; i < n; i++) pushOne(32'h8000 + 32'(i * 64), 1'b0);
      rspInValid = 1'b1;
      rspInData  = 32'hC0DE0000 + 32'(n);
      check("R10 buffer free", 64'(rspInReady), 64'd1);
      tick();
      rspInData = 32'hDEAD0000 + 32'(n);
      check("R10 buffer taken", 64'(rspInReady), 64'd0);
      rspInValid = 1'b0;
      if (n < DEP) pushOne(32'h9000, 1'b1);
      invReady = 2'b11;
      ackValid = 2'b11;
      seen = 0;
      for (int cyc = 0; cyc < 4 * n + 12; cyc++) begin
        check("R6 release cycle", 64'(rspOutValid), 64'(seen >= n));
        check("R10 held blocks input", 64'(rspInReady), 64'd0);
        syncReady = (seen < n);
        if (syncValid && syncReady) seen++;
        tick();
      end
      syncReady = 1'b0;
      check("R6 syncs before release", 64'(seen), 64'(n));
      check("R7 released despite later", 64'(rspOutValid), 64'd1);
      check("R7 later still pending", 64'(statusPending), (n < DEP) ? 64'b10 : 64'b00);
      check("R10 data", 64'(rspOutData), 64'(32'hC0DE0000 + 32'(n)));
      rspOutReady = 1'b1;
      tick();
      rspOutReady = 1'b0;
      check("R10 emptied", 64'(rspOutValid), 64'd0);
      check("R10 free again", 64'(rspInReady), 64'd1);
      syncReady = 1'b1;
      repeat (12) tick();
      syncReady = 1'b0;
      invReady  = 2'b00;
      ackValid  = 2'b00;
      check("R8 drained", 64'(statusPending), 64'd0);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule